// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers completion events from a set of DMA channels and turns them into four host interrupt lines. Every channel owns a five-bit event status register, which latches cause pulses from its data mover, and a five-bit event control register that selects which causes count. A channel whose selected causes are non-zero is "qualified". Each qualified channel marks its bit in four parallel global pending registers. Each pending register is paired with a global enable register, and each pair drives one interrupt output.

Software reaches everything through a simple word-addressed register port. It writes control and enable registers directly. It clears status and pending bits by writing ones. It reads a global idle vector that reflects the per-channel idle inputs. Register reads return data one cycle after the request. The usual service sequence clears the channel status first and then the global pending bit.

Top module: `irqagg_top`

## Requirements
- R1: After reset, every control, status, pending and enable register reads zero, all four interrupt outputs are low, and read data is zero.
- R2: A pulse on event input bit `c*5+k` sets status bit k of channel c, and the bit stays set until software clears it. The cause encoding is: bit 0 block done, bit 1 whole chain done, bit 2 frame done, bit 3 half frame, bit 4 last frame. The control register does not gate this latching.
- R3: Channel status (offset 0x44 in the channel's page) is write-one-to-clear. Zero bits in the write data leave their status bits unchanged. An event arriving in the same cycle as the clear of its bit keeps the bit set.
- R4: While (control AND status) of channel c is non-zero, bit c is set in all four pending registers (global offsets 0x00, 0x04, 0x08, 0x0C) one cycle later. Otherwise no pending bit is set for that channel.
- R5: Pending registers are write-one-to-clear and independent of one another. Writing zero has no effect. A clear of a bit whose channel is still qualified leaves the bit set.
- R6: Interrupt output b is high one cycle after (pending[b] AND enable[b]) is non-zero, and low one cycle after it becomes zero.
- R7: Enable registers (global offsets 0x10, 0x14, 0x18, 0x1C, paired with pending 0..3 in that order) are plain read/write. Only the low NUM_CH bits are stored.
- R8: Channel control (offset 0x40 in the page at 0x100 + c*0x100) is plain read/write. Only five bits are stored per channel.
- R9: Global offset 0x2C reads the idle inputs, with bit c set while channel c is idle. Writes to it have no effect.
- R10: All other offsets read zero and ignore writes. This includes pages of channels at or beyond NUM_CH and unused channel offsets.
- R11: Read data is valid in the cycle after a read request and is zero in every cycle that does not follow a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_CH*5 | Cause pulses, five per channel |
| idle_i | input | NUM_CH | Per-channel idle flags from the movers |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, one cycle after the request |
| irq_o | output | 4 | Interrupt lines, one per pending/enable pair |

## Verification
The bench goes after the collisions between hardware setting and software clearing. An event during a status clear must survive, or a completion would be silently lost. A pending clear while the channel is still qualified must leave the bit set, or the interrupt would drop with its cause unserviced. The bench checks that the four pending banks clear independently, which catches a design that clears all banks from one write. It probes out-of-range channel pages, unused offsets and the read-only idle word, because a loose decoder would alias those onto real registers. It also checks that a masked cause latches in status but never reaches pending.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int CAUSE_W = 5;

    // cause bit positions inside each channel status/control word
    localparam int CAUSE_BLOCK      = 0;
    localparam int CAUSE_CHAIN      = 1;
    localparam int CAUSE_FRAME      = 2;
    localparam int CAUSE_HALF_FRAME = 3;
    localparam int CAUSE_LAST_FRAME = 4;

    // register offsets
    localparam logic [7:0] OFF_IDLE = 8'h2C;
    localparam logic [7:0] OFF_CTRL = 8'h40;
    localparam logic [7:0] OFF_STAT = 8'h44;

    typedef enum logic [2:0] {
        RD_NONE,
        RD_PEND,
        RD_EN,
        RD_IDLE,
        RD_CTRL,
        RD_STAT
    } rd_kind_e;

endpackage

// File: rtl/irqagg_regdec.sv
module irqagg_regdec
    import irqagg_pkg::*;
#(
    parameter int NUM_CH   = 6,
    parameter int NUM_BANK = 4,
    parameter int ADDR_W   = 12,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int BANK_W  = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1
) (
    input  logic                reg_en,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    output logic [NUM_BANK-1:0] pend_w1c,
    output logic [NUM_BANK-1:0] en_we,
    output logic [NUM_CH-1:0]   ctrl_we,
    output logic [NUM_CH-1:0]   stat_w1c,
    output rd_kind_e            rd_kind,
    output logic [BANK_W-1:0]   rd_bank,
    output logic [CH_W-1:0]     rd_ch
);

    localparam int PAGE_W = ADDR_W - 8;

    logic [PAGE_W-1:0] page;
    logic [7:0]        off;
    rd_kind_e          hit;
    logic [BANK_W-1:0] bank_idx;
    logic [CH_W-1:0]   ch_idx;

    assign page = reg_addr[ADDR_W-1:8];
    assign off  = reg_addr[7:0];

    always_comb begin
        hit      = RD_NONE;
        bank_idx = BANK_W'(off[3:2]);
        ch_idx   = CH_W'(page - 1'b1);
        if (reg_en && off[1:0] == 2'b00) begin
            if (page == '0) begin
                if (off[7:4] == 4'h0 && int'(off[3:2]) < NUM_BANK) begin
                    hit = RD_PEND;
                end else if (off[7:4] == 4'h1 && int'(off[3:2]) < NUM_BANK) begin
                    hit = RD_EN;
                end else if (off == OFF_IDLE) begin
                    hit = RD_IDLE;
                end
            end else if (int'(page) <= NUM_CH) begin
                if (off == OFF_CTRL) begin
                    hit = RD_CTRL;
                end else if (off == OFF_STAT) begin
                    hit = RD_STAT;
                end
            end
        end
    end

    always_comb begin
        pend_w1c = '0;
        en_we    = '0;
        ctrl_we  = '0;
        stat_w1c = '0;
        if (reg_we) begin
            case (hit)
                RD_PEND: pend_w1c = NUM_BANK'(1) << bank_idx;
                RD_EN:   en_we    = NUM_BANK'(1) << bank_idx;
                RD_CTRL: ctrl_we  = NUM_CH'(1) << ch_idx;
                RD_STAT: stat_w1c = NUM_CH'(1) << ch_idx;
                default: ;
            endcase
        end
        rd_kind = reg_we ? RD_NONE : hit;
        rd_bank = bank_idx;
        rd_ch   = ch_idx;
    end

endmodule

// File: rtl/irqagg_chan.sv
module irqagg_chan
    import irqagg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] evt_i,
    input  logic               ctrl_we,
    input  logic               stat_w1c,
    input  logic [CAUSE_W-1:0] wdata,
    output logic [CAUSE_W-1:0] ctrl_o,
    output logic [CAUSE_W-1:0] stat_o,
    output logic               qual_o
);

    typedef struct packed {
        logic [CAUSE_W-1:0] ctrl;
        logic [CAUSE_W-1:0] stat;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_we) begin
            st_d.ctrl = wdata;
        end
        if (stat_w1c) begin
            st_d.stat = st_q.stat & ~wdata;
        end
        // a fresh event beats a simultaneous clear
        st_d.stat = st_d.stat | evt_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o = st_q.ctrl;
    assign stat_o = st_q.stat;
    assign qual_o = |(st_q.ctrl & st_q.stat);

endmodule

// File: rtl/irqagg_bank.sv
module irqagg_bank #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_i,
    input  logic              en_we,
    input  logic              pend_w1c,
    input  logic [NUM_CH-1:0] wdata,
    output logic [NUM_CH-1:0] pend_o,
    output logic [NUM_CH-1:0] en_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] pend;
        logic [NUM_CH-1:0] en;
        logic              irq;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_we) begin
            st_d.en = wdata;
        end
        if (pend_w1c) begin
            st_d.pend = st_q.pend & ~wdata;
        end
        st_d.pend = st_d.pend | set_i;
        st_d.irq  = |(st_q.pend & st_q.en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign en_o   = st_q.en;
    assign irq_o  = st_q.irq;

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int NUM_CH   = 6,
    parameter int NUM_BANK = 4,
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CH*5-1:0]   evt_i,
    input  logic [NUM_CH-1:0]     idle_i,
    input  logic                  reg_en,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic [NUM_BANK-1:0]   irq_o
);

    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int BANK_W = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1;

    logic [NUM_BANK-1:0]             pend_w1c;
    logic [NUM_BANK-1:0]             en_we;
    logic [NUM_CH-1:0]               ctrl_we;
    logic [NUM_CH-1:0]               stat_w1c;
    rd_kind_e                        rd_kind;
    logic [BANK_W-1:0]               rd_bank;
    logic [CH_W-1:0]                 rd_ch;

    logic [NUM_CH-1:0][CAUSE_W-1:0]  chan_ctrl;
    logic [NUM_CH-1:0][CAUSE_W-1:0]  chan_stat;
    logic [NUM_CH-1:0]               chan_qual;
    logic [NUM_BANK-1:0][NUM_CH-1:0] bank_pend;
    logic [NUM_BANK-1:0][NUM_CH-1:0] bank_en;

    irqagg_regdec #(
        .NUM_CH   (NUM_CH),
        .NUM_BANK (NUM_BANK),
        .ADDR_W   (ADDR_W)
    ) u_regdec (
        .reg_en   (reg_en),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .pend_w1c (pend_w1c),
        .en_we    (en_we),
        .ctrl_we  (ctrl_we),
        .stat_w1c (stat_w1c),
        .rd_kind  (rd_kind),
        .rd_bank  (rd_bank),
        .rd_ch    (rd_ch)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        irqagg_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_i    (evt_i[c*CAUSE_W +: CAUSE_W]),
            .ctrl_we  (ctrl_we[c]),
            .stat_w1c (stat_w1c[c]),
            .wdata    (reg_wdata[CAUSE_W-1:0]),
            .ctrl_o   (chan_ctrl[c]),
            .stat_o   (chan_stat[c]),
            .qual_o   (chan_qual[c])
        );
    end

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        irqagg_bank #(
            .NUM_CH (NUM_CH)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (chan_qual),
            .en_we    (en_we[b]),
            .pend_w1c (pend_w1c[b]),
            .wdata    (reg_wdata[NUM_CH-1:0]),
            .pend_o   (bank_pend[b]),
            .en_o     (bank_en[b]),
            .irq_o    (irq_o[b])
        );
    end

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    always_comb begin
        st_d.rdata = '0;
        case (rd_kind)
            RD_PEND: st_d.rdata = DATA_W'(bank_pend[rd_bank]);
            RD_EN:   st_d.rdata = DATA_W'(bank_en[rd_bank]);
            RD_IDLE: st_d.rdata = DATA_W'(idle_i);
            RD_CTRL: st_d.rdata = DATA_W'(chan_ctrl[rd_ch]);
            RD_STAT: st_d.rdata = DATA_W'(chan_stat[rd_ch]);
            default: st_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata = st_q.rdata;

endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker #(
    parameter int NUM_CH   = 6,
    parameter int NUM_BANK = 4,
    parameter int DATA_W   = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      reg_en,
    input logic                      reg_we,
    input logic [DATA_W-1:0]         reg_rdata,
    input logic [NUM_BANK-1:0]       irq_o,
    input logic [NUM_CH*5-1:0]       evt_i,
    input logic [NUM_CH-1:0][4:0]    chan_stat,
    input logic [NUM_CH-1:0]         chan_qual,
    input logic [NUM_CH-1:0]         stat_w1c,
    input logic [NUM_BANK-1:0][NUM_CH-1:0] bank_pend,
    input logic [NUM_BANK-1:0][NUM_CH-1:0] bank_en,
    input logic [NUM_BANK-1:0]       pend_w1c
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_c
        for (genvar k = 0; k < 5; k++) begin : g_k
            a_r2_event_sticks: assert property (@(posedge clk) disable iff (!rst_n)
                evt_i[c*5+k] |=> chan_stat[c][k]);
            a_r3_stat_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(chan_stat[c][k]) |-> $past(stat_w1c[c]));
        end
        for (genvar b = 0; b < NUM_BANK; b++) begin : g_b
            a_r4_qual_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
                chan_qual[c] |=> bank_pend[b][c]);
            a_r5_pend_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(bank_pend[b][c]) |-> $past(pend_w1c[b]));
        end
    end

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_irq
        a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_o[b]) |-> $past(bank_en[b] != '0));
    end

    a_r11_rdata_zero_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_en && !reg_we) |-> reg_rdata == '0);

endmodule

bind irqagg_top irqagg_checker #(
    .NUM_CH   (NUM_CH),
    .NUM_BANK (NUM_BANK),
    .DATA_W   (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o),
    .evt_i     (evt_i),
    .chan_stat (chan_stat),
    .chan_qual (chan_qual),
    .stat_w1c  (stat_w1c),
    .bank_pend (bank_pend),
    .bank_en   (bank_en),
    .pend_w1c  (pend_w1c)
);

// File: tb/irqagg_top_bench.sv
module irqagg_top_bench;

    localparam int NUM_CH = 6;
    localparam int AW     = 12;
    localparam int DW     = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NUM_CH*5-1:0] evt_i;
    logic [NUM_CH-1:0] idle_i;
    logic              reg_en;
    logic              reg_we;
    logic [AW-1:0]     reg_addr;
    logic [DW-1:0]     reg_wdata;
    logic [DW-1:0]     reg_rdata;
    logic [3:0]        irq_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irqagg_top u_irqagg_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .idle_i    (idle_i),
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o)
    );

    typedef struct packed {
        logic        rd;
        logic [3:0]  req;
        logic [11:0] addr;
        logic [31:0] data;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 4'd8,  12'h140, 32'hFFFF_FFFF},
        '{1'b1, 4'd8,  12'h140, 32'h0000_001F},   // R8 five bits kept
        '{1'b0, 4'd8,  12'h240, 32'h0000_000A},
        '{1'b1, 4'd8,  12'h240, 32'h0000_000A},   // R8
        '{1'b1, 4'd8,  12'h140, 32'h0000_001F},   // R8 channels independent
        '{1'b0, 4'd7,  12'h010, 32'hFFFF_FFFF},
        '{1'b1, 4'd7,  12'h010, 32'h0000_003F},   // R7 NUM_CH bits kept
        '{1'b0, 4'd7,  12'h01C, 32'h0000_0015},
        '{1'b1, 4'd7,  12'h01C, 32'h0000_0015},   // R7
        '{1'b1, 4'd7,  12'h014, 32'h0000_0000},   // R7 other enable untouched
        '{1'b0, 4'd10, 12'h020, 32'hFFFF_FFFF},
        '{1'b1, 4'd10, 12'h020, 32'h0000_0000},   // R10 unused global
        '{1'b0, 4'd10, 12'h740, 32'h0000_001F},
        '{1'b1, 4'd10, 12'h740, 32'h0000_0000},   // R10 channel beyond range
        '{1'b1, 4'd10, 12'h148, 32'h0000_0000},   // R10 unused channel offset
        '{1'b0, 4'd9,  12'h02C, 32'h0000_00FF},
        '{1'b1, 4'd9,  12'h02C, 32'h0000_0029},   // R9 idle read-only
        '{1'b1, 4'd2,  12'h144, 32'h0000_0000},   // R2 ctrl sets no status
        '{1'b1, 4'd4,  12'h000, 32'h0000_0000}    // R4 no event, no pending
    };

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        evt_i     = '0;
        reg_en    = 1'b0;
        reg_we    = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // write; evt is driven in the same cycle as the write
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [NUM_CH*5-1:0] evt);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d; evt_i = evt;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0; evt_i = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        reg_en = 1'b0;
    endtask

    task automatic pulse(input logic [NUM_CH*5-1:0] evt);
        evt_i = evt;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] v;
        idle_i = 6'b101001;
        do_reset();

        // R1 reset state
        check("R1 irq", DW'(irq_o), 0);
        check("R1 rdata", reg_rdata, 0);
        rd(12'h000, v); check("R1 pend0", v, 0);
        rd(12'h344, v); check("R1 stat2", v, 0);

        // register table
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].rd) begin
                rd(VECS[i].addr, v);
                checks++;
                if (v !== VECS[i].data) begin
                    errors++;
                    $display("FAIL R%0d: addr %h actual %h expected %h",
                             VECS[i].req, VECS[i].addr, v, VECS[i].data);
                end
            end else begin
                wr(VECS[i].addr, VECS[i].data, '0);
            end
        end
        check("R6 irq no pending", DW'(irq_o), 0);

        // R11 zero in idle cycle
        @(negedge clk);
        check("R11 idle rdata", reg_rdata, 0);

        // R9 dynamic idle
        idle_i = 6'b010110;
        rd(12'h02C, v); check("R9 idle follows", v, 32'h16);

        do_reset();
        // ch2 ctrl = chain-done, bank1 enables ch2
        wr(12'h340, 32'h02, '0);
        wr(12'h014, 32'h04, '0);
        pulse(30'(5'b00010) << 10);
        rd(12'h344, v); check("R2 stat ch2", v, 32'h02);
        rd(12'h000, v); check("R4 pend0", v, 32'h04);
        rd(12'h00C, v); check("R4 pend3", v, 32'h04);
        check("R6 irq raised", DW'(irq_o), 32'h2);

        // R2 masked cause on ch3 latches but stays out of pending
        pulse(30'(5'b00001) << 15);
        rd(12'h444, v); check("R2 masked stat", v, 32'h01);
        rd(12'h008, v); check("R4 masked no pend", v, 32'h04);

        // R5 clear while still qualified: set wins
        wr(12'h004, 32'h04, '0);
        rd(12'h004, v); check("R5 set wins", v, 32'h04);

        // R3 clear status, then R5 clear bank1 only
        wr(12'h344, 32'h02, '0);
        rd(12'h344, v); check("R3 stat cleared", v, 0);
        wr(12'h004, 32'h04, '0);
        rd(12'h004, v); check("R5 bank1 cleared", v, 0);
        check("R6 irq dropped", DW'(irq_o), 0);
        rd(12'h000, v); check("R5 bank0 untouched", v, 32'h04);
        wr(12'h000, 32'h00, '0);
        rd(12'h000, v); check("R5 zero write", v, 32'h04);
        wr(12'h000, 32'h04, '0);
        rd(12'h000, v); check("R5 bank0 cleared", v, 0);

        // R3 event during clear of its own bit survives
        wr(12'h444, 32'h01, 30'(5'b00001) << 15);
        rd(12'h444, v); check("R3 event beats clear", v, 32'h01);
        pulse(30'(5'b10000) << 15);
        wr(12'h444, 32'h10, '0);
        rd(12'h444, v); check("R3 partial clear", v, 32'h01);
        wr(12'h444, 32'h01, '0);
        rd(12'h444, v); check("R3 full clear", v, 0);

        // R6 enable after pending raises irq on bank 3 only
        wr(12'h640, 32'h08, '0);            // ch5 half-frame
        pulse(30'(5'b01000) << 25);
        wr(12'h01C, 32'h20, '0);
        @(negedge clk);
        check("R6 bank3 irq", DW'(irq_o), 32'h8);

        finish_run();
    end

endmodule